// File: doc/BRIEF.md
# Peripheral FIFO Pair with Threshold Ready Flags

This block sits between a register bus and the byte shifter of a serial bus controller. It holds a transmit queue and a receive queue, each `DEPTH` bytes deep (4 to 63). Software, or a DMA engine, reaches the queues through two holding-register addresses. Each access carries either one byte or four bytes, and a four-byte word is packed little-endian. The shifter side is modelled as two byte streams with valid/ready handshakes.

Each direction drives a ready flag meant for a DMA request or an interrupt. On the transmit side the flag rises once a programmed number of slots (one, two or four) is free. On the receive side it rises once that many bytes are stored, so a DMA channel that moves words is only triggered when a whole word can move. The queues can be switched off. When off, each direction becomes a single-byte holding register. A command register enables, disables and empties the queues, and clears a transmit lock. The lock is set by a transfer error and stops the transmit stream until software clears it.

Back-pressure rules:
- The transmit stream moves a byte on any cycle where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, the head byte stays on `tx_data`.
- `rx_ready` is high exactly when the receive queue has room. A byte offered while `rx_ready` is low is not taken, and the producer must hold it.

Top module: `serial_fifo_pair`

## Requirements
- R1: After reset the queues are off (STATUS bit 5 = 0), both are empty, MODE reads 0, the lock and both sticky errors are clear, `tx_valid` is low and `rx_ready` is high.
- R2: A byte write (`reg_word`=0) to THR at 0x34 appends `reg_wdata[7:0]` to the transmit queue. Bytes leave on `tx_data` in the order written. A byte read of RHR at 0x30 returns the oldest received byte in bits [7:0], with zeros above, and removes it.
- R3: A word write (`reg_word`=1) to THR is taken only when at least four slots are free. It appends bits [7:0], then [15:8], then [23:16], then [31:24]. A word read of RHR needs at least four stored bytes. It removes four bytes and returns the oldest in [7:0] and the fourth oldest in [31:24].
- R4: A THR write without enough room is dropped and sets the sticky overflow bit (STATUS bit 3). An RHR read with too few bytes removes nothing, returns 0 and sets the sticky underflow bit (STATUS bit 4). Counts never exceed `DEPTH`.
- R5: MODE at 0x50 holds the transmit threshold code in [1:0] and the receive threshold code in [5:4]. Codes decode as 0 = one, 1 = two, 2 = four and 3 = one. `tx_space_flag` is high when free slots are at least the threshold, and `rx_data_flag` is high when stored bytes are at least the threshold. The two flags also read back as STATUS bits 0 and 1.
- R6: While the queues are off, each direction holds at most one byte and both thresholds act as one. A word access then always fails under R4.
- R7: CTRL at 0x00 bit 28 turns the queues on and bit 29 turns them off. Bit 29 wins when both are set. Either command empties both queues. When on, each direction holds `DEPTH` bytes.
- R8: CTRL bit 24 empties the transmit queue and clears the overflow bit. Bit 25 empties the receive queue and clears the underflow bit. Both can be set in one write, and an emptying command wins over a shifter transfer in the same cycle.
- R9: A high `xfer_error` locks the transmit path from the next cycle (`tx_frozen`, STATUS bit 2). While locked, `tx_valid` stays low but THR writes are still taken. CTRL bit 26 clears the lock, and an error in the same cycle wins over the clear.
- R10: LEVEL at 0x54 reads the transmit count in [5:0] and the receive count in [21:16].
- R11: `tx_valid` is high exactly when the transmit queue holds data and the path is unlocked. A stalled head byte stays stable. `rx_ready` is high exactly when the receive count is below the present capacity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on RHR) |
| reg_addr | input | 8 | Register byte offset |
| reg_word | input | 1 | 1 = four-byte access, 0 = one byte |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from address |
| tx_valid | output | 1 | Transmit byte available to the shifter |
| tx_ready | input | 1 | Shifter takes the byte |
| tx_data | output | 8 | Head of transmit queue |
| rx_valid | input | 1 | Shifter offers a received byte |
| rx_ready | output | 1 | Receive queue has room |
| rx_data | input | 8 | Received byte |
| xfer_error | input | 1 | Transfer error, sets the lock |
| tx_space_flag | output | 1 | Transmit threshold met |
| rx_data_flag | output | 1 | Receive threshold met |
| tx_frozen | output | 1 | Transmit lock state |

## Verification
The bench aims at the edges of every threshold. A free count of exactly four must raise the four-slot flag, and three stored bytes must keep the receive flag low. A word write into exactly four free slots must be taken, while one into three must be refused without losing the first byte. A design that checked room after the same-cycle pop, or packed the word big-endian, would show at once as a wrong level or a wrong byte order on `tx_data`.

It also covers collisions:
- error and unlock in one write;
- enable and disable set together;
- an emptying command racing a shifter transfer;
- word accesses made while the queues are off.

A design that got any of these wrong would leave a stale byte behind, drop the lock, or let four bytes into a one-byte register. Long mixed traffic against a queue model catches pointer wrap faults.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  localparam logic [7:0] ADDR_CTRL  = 8'h00;
  localparam logic [7:0] ADDR_RHR   = 8'h30;
  localparam logic [7:0] ADDR_THR   = 8'h34;
  localparam logic [7:0] ADDR_MODE  = 8'h50;
  localparam logic [7:0] ADDR_LEVEL = 8'h54;
  localparam logic [7:0] ADDR_STAT  = 8'h60;

  localparam int CB_TXFLUSH = 24;
  localparam int CB_RXFLUSH = 25;
  localparam int CB_UNLOCK  = 26;
  localparam int CB_ENABLE  = 28;
  localparam int CB_DISABLE = 29;

  typedef enum logic [1:0] {
    THR_ONE  = 2'd0,
    THR_TWO  = 2'd1,
    THR_FOUR = 2'd2,
    THR_RSVD = 2'd3
  } thr_code_e;

  // Entries needed for a ready flag; thresholds collapse to one when off.
  function automatic logic [2:0] thr_entries(input thr_code_e code, input logic fifo_on);
    if (!fifo_on) return 3'd1;
    case (code)
      THR_TWO:  return 3'd2;
      THR_FOUR: return 3'd4;
      default:  return 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/sfp_fifo.sv
module sfp_fifo #(
  parameter int DEPTH = 16,
  parameter int LANES = 4,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int AW = $clog2(DEPTH),
  localparam int NW = $clog2(LANES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic [NW-1:0]      wr_n,
  input  logic [LANES*8-1:0] wr_data,
  input  logic [NW-1:0]      rd_n,
  output logic [LANES*8-1:0] rd_data,
  output logic [CW-1:0]      count
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;

  function automatic logic [AW-1:0] wrap(input logic [AW-1:0] base, input int off);
    int s;
    s = int'(base) + off;
    if (s >= DEPTH) s = s - DEPTH;
    return s[AW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!clr) begin
      for (int i = 0; i < LANES; i++) begin
        if (i < int'(wr_n)) mem[wrap(wp, i)] <= wr_data[i*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      wp    <= wrap(wp, int'(wr_n));
      rp    <= wrap(rp, int'(rd_n));
      count <= count + CW'(wr_n) - CW'(rd_n);
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_peek
    assign rd_data[g*8 +: 8] = mem[wrap(rp, g)];
  end
endmodule

// File: rtl/sfp_flags.sv
module sfp_flags import sfp_pkg::*; #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic      fifo_on,
  input  thr_code_e tx_code,
  input  thr_code_e rx_code,
  input  logic [CW-1:0] tx_cnt,
  input  logic [CW-1:0] rx_cnt,
  input  logic [CW-1:0] cap,
  output logic      tx_hit,
  output logic      rx_hit
);
  logic [CW-1:0] tx_free, tx_need, rx_need;

  assign tx_free = cap - tx_cnt;
  assign tx_need = CW'(thr_entries(tx_code, fifo_on));
  assign rx_need = CW'(thr_entries(rx_code, fifo_on));
  assign tx_hit  = tx_free >= tx_need;
  assign rx_hit  = rx_cnt >= rx_need;
endmodule

// File: rtl/sfp_ctrl.sv
module sfp_ctrl import sfp_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_wr,
  input  logic        mode_wr,
  input  logic [31:0] wdata,
  input  logic        xfer_error,
  input  logic        ovf_set,
  input  logic        udf_set,
  output logic        fifo_on,
  output thr_code_e   tx_code,
  output thr_code_e   rx_code,
  output logic        locked,
  output logic        ovf,
  output logic        udf,
  output logic        flush_tx,
  output logic        flush_rx
);
  logic go_off, go_on, unused_wbits;

  assign unused_wbits = ^{wdata[31:30], wdata[27], wdata[23:6], wdata[3:2]};
  assign go_off   = ctrl_wr && wdata[CB_DISABLE];
  assign go_on    = ctrl_wr && wdata[CB_ENABLE] && !wdata[CB_DISABLE];
  assign flush_tx = go_off || go_on || (ctrl_wr && wdata[CB_TXFLUSH]);
  assign flush_rx = go_off || go_on || (ctrl_wr && wdata[CB_RXFLUSH]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_on <= 1'b0;
      tx_code <= THR_ONE;
      rx_code <= THR_ONE;
      locked  <= 1'b0;
      ovf     <= 1'b0;
      udf     <= 1'b0;
    end else begin
      if (go_off)     fifo_on <= 1'b0;
      else if (go_on) fifo_on <= 1'b1;
      if (mode_wr) begin
        tx_code <= thr_code_e'(wdata[1:0]);
        rx_code <= thr_code_e'(wdata[5:4]);
      end
      if (xfer_error)                         locked <= 1'b1;
      else if (ctrl_wr && wdata[CB_UNLOCK])   locked <= 1'b0;
      if (ovf_set)                            ovf <= 1'b1;
      else if (ctrl_wr && wdata[CB_TXFLUSH])  ovf <= 1'b0;
      if (udf_set)                            udf <= 1'b1;
      else if (ctrl_wr && wdata[CB_RXFLUSH])  udf <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_fifo_pair.sv
module serial_fifo_pair import sfp_pkg::*; #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int LANES = 4,
  localparam int NW = $clog2(LANES + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [7:0]  reg_addr,
  input  logic        reg_word,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [7:0]  rx_data,
  input  logic        xfer_error,
  output logic        tx_space_flag,
  output logic        rx_data_flag,
  output logic        tx_frozen
);
  logic fifo_on, locked, ovf, udf, flush_tx, flush_rx;
  thr_code_e tx_code, rx_code;
  logic [CW-1:0] tx_cnt, rx_cnt, cap;
  logic [NW-1:0] access_n, tx_wn, tx_rn, rx_wn, rx_rn;
  logic [LANES*8-1:0] tx_lanes, rx_lanes;
  logic ctrl_wr, mode_wr, thr_wr, rhr_rd;
  logic tx_room_ok, rx_have_ok, tx_pop, rx_push, unused_tx_upper;

  assign ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);
  assign mode_wr = reg_wr && (reg_addr == ADDR_MODE);
  assign thr_wr  = reg_wr && (reg_addr == ADDR_THR);
  assign rhr_rd  = reg_rd && (reg_addr == ADDR_RHR);

  assign cap        = fifo_on ? CW'(DEPTH) : CW'(1);
  assign access_n   = reg_word ? NW'(4) : NW'(1);
  assign tx_room_ok = (cap - tx_cnt) >= CW'(access_n);
  assign rx_have_ok = rx_cnt >= CW'(access_n);

  assign tx_wn   = (thr_wr && tx_room_ok) ? access_n : '0;
  assign rx_rn   = (rhr_rd && rx_have_ok) ? access_n : '0;
  assign tx_valid = !locked && (tx_cnt != '0);
  assign tx_pop  = tx_valid && tx_ready;
  assign tx_rn   = tx_pop ? NW'(1) : '0;
  assign rx_ready = rx_cnt < cap;
  assign rx_push = rx_valid && rx_ready;
  assign rx_wn   = rx_push ? NW'(1) : '0;

  assign tx_data   = tx_lanes[7:0];
  assign tx_frozen = locked;
  assign unused_tx_upper = ^tx_lanes[LANES*8-1:8];

  sfp_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .mode_wr(mode_wr),
    .wdata(reg_wdata), .xfer_error(xfer_error),
    .ovf_set(thr_wr && !tx_room_ok), .udf_set(rhr_rd && !rx_have_ok),
    .fifo_on(fifo_on), .tx_code(tx_code), .rx_code(rx_code), .locked(locked),
    .ovf(ovf), .udf(udf), .flush_tx(flush_tx), .flush_rx(flush_rx)
  );

  sfp_fifo #(.DEPTH(DEPTH), .LANES(LANES)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(flush_tx), .wr_n(tx_wn), .wr_data(reg_wdata),
    .rd_n(tx_rn), .rd_data(tx_lanes), .count(tx_cnt)
  );

  sfp_fifo #(.DEPTH(DEPTH), .LANES(LANES)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(flush_rx), .wr_n(rx_wn),
    .wr_data({{(LANES*8-8){1'b0}}, rx_data}),
    .rd_n(rx_rn), .rd_data(rx_lanes), .count(rx_cnt)
  );

  sfp_flags #(.DEPTH(DEPTH)) u_flags (
    .fifo_on(fifo_on), .tx_code(tx_code), .rx_code(rx_code),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .cap(cap),
    .tx_hit(tx_space_flag), .rx_hit(rx_data_flag)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_MODE:  reg_rdata = {26'b0, rx_code, 2'b0, tx_code};
      ADDR_LEVEL: reg_rdata = {10'b0, 6'(rx_cnt), 10'b0, 6'(tx_cnt)};
      ADDR_STAT:  reg_rdata = {26'b0, fifo_on, udf, ovf, locked, rx_data_flag, tx_space_flag};
      ADDR_RHR: begin
        if (rx_have_ok) reg_rdata = reg_word ? rx_lanes : {24'b0, rx_lanes[7:0]};
      end
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/serial_fifo_pair_chk.sv
module serial_fifo_pair_chk #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [7:0]    reg_addr,
  input logic [31:0]   reg_wdata,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data,
  input logic          xfer_error,
  input logic          tx_frozen,
  input logic          fifo_on,
  input logic          ovf,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt
);
  logic ctl;
  assign ctl = reg_wr && (reg_addr == 8'h00);

  assert_frozen_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_frozen |-> !tx_valid);

  assert_lock_on_error_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_error |=> tx_frozen);

  assert_head_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !xfer_error && !ctl) |=> (tx_valid && $stable(tx_data)));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(tx_cnt) <= DEPTH) && (int'(rx_cnt) <= DEPTH));

  assert_sticky_ovf_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !(ctl && reg_wdata[24])) |=> ovf);

  assert_single_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_on |-> (tx_cnt <= CW'(1)) && (rx_cnt <= CW'(1)));

  assert_flush_tx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl && reg_wdata[24]) |=> (tx_cnt == '0));
endmodule

bind serial_fifo_pair serial_fifo_pair_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .xfer_error(xfer_error),
  .tx_frozen(tx_frozen), .fifo_on(fifo_on), .ovf(ovf), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/sim_serial_fifo_pair.sv
module sim_serial_fifo_pair;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam logic [7:0] A_CTRL = 8'h00, A_RHR = 8'h30, A_THR = 8'h34;
  localparam logic [7:0] A_MODE = 8'h50, A_LEVEL = 8'h54, A_STAT = 8'h60;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0, reg_word = 0, tx_ready = 0, rx_valid = 0, xfer_error = 0;
  logic [7:0] reg_addr = 0, rx_data = 0, tx_data;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic tx_valid, rx_ready, tx_space_flag, rx_data_flag, tx_frozen;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_fifo_pair #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_word(reg_word), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .xfer_error(xfer_error), .tx_space_flag(tx_space_flag),
    .rx_data_flag(rx_data_flag), .tx_frozen(tx_frozen)
  );

  int n_checks = 0, n_fail = 0;

  // Behavioural reference model
  logic [7:0] txq[$], rxq[$];
  bit m_on = 0, m_lock = 0, m_ovf = 0, m_udf = 0;
  logic [1:0] m_txc = 0, m_rxc = 0;

  // Stimulus for the next cycle
  logic s_wr = 0, s_rd = 0, s_word = 0, s_txr = 0, s_rxv = 0, s_err = 0;
  logic [7:0] s_addr = 0, s_rxd = 0;
  logic [31:0] s_wd = 0;
  string rd_tag = "R2";

  function automatic int need(logic [1:0] c);
    if (!m_on) return 1;
    case (c)
      2'd1: return 2;
      2'd2: return 4;
      default: return 1;
    endcase
  endfunction

  function automatic int capn();
    return m_on ? DEPTH : 1;
  endfunction

  function automatic bit e_txflag();
    return (capn() - txq.size()) >= need(m_txc);
  endfunction

  function automatic bit e_rxflag();
    return rxq.size() >= need(m_rxc);
  endfunction

  function automatic logic [31:0] exp_rdata();
    int n;
    n = s_word ? 4 : 1;
    case (s_addr)
      A_MODE:  return {26'b0, m_rxc, 2'b0, m_txc};
      A_LEVEL: return {10'b0, 6'(rxq.size()), 10'b0, 6'(txq.size())};
      A_STAT:  return {26'b0, m_on, m_udf, m_ovf, m_lock, e_rxflag(), e_txflag()};
      A_RHR: begin
        if (rxq.size() < n) return 32'h0;
        if (s_word) return {rxq[3], rxq[2], rxq[1], rxq[0]};
        return {24'b0, rxq[0]};
      end
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_update();
    int  cap = capn();
    int  n = s_word ? 4 : 1;
    bit  ctl = s_wr && (s_addr == A_CTRL);
    bit  off = ctl && s_wd[29];
    bit  on = ctl && s_wd[28] && !s_wd[29];
    bit  ftx = off || on || (ctl && s_wd[24]);
    bit  frx = off || on || (ctl && s_wd[25]);
    bit  tpop = !m_lock && (txq.size() > 0) && s_txr;
    bit  rpush = s_rxv && (rxq.size() < cap);
    bit  do_push = 0, do_pop = 0;
    if (s_wr && s_addr == A_THR) begin
      if (cap - txq.size() >= n) do_push = 1; else m_ovf = 1;
    end
    if (s_rd && s_addr == A_RHR) begin
      if (rxq.size() >= n) do_pop = 1; else m_udf = 1;
    end
    if (s_wr && s_addr == A_MODE) begin
      m_txc = s_wd[1:0];
      m_rxc = s_wd[5:4];
    end
    if (ctl && s_wd[24]) m_ovf = 0;
    if (ctl && s_wd[25]) m_udf = 0;
    if (s_err) m_lock = 1;
    else if (ctl && s_wd[26]) m_lock = 0;
    if (off) m_on = 0;
    else if (on) m_on = 1;
    if (ftx) txq.delete();
    else begin
      if (tpop) void'(txq.pop_front());
      if (do_push) for (int i = 0; i < n; i++) txq.push_back(s_wd[i*8 +: 8]);
    end
    if (frx) rxq.delete();
    else begin
      if (do_pop) for (int i = 0; i < n; i++) void'(rxq.pop_front());
      if (rpush) rxq.push_back(s_rxd);
    end
  endtask

  // One clock: compare state outputs, apply stimulus, compare read data, advance model.
  task automatic step();
    bit etv;
    @(negedge clk);
    etv = !m_lock && (txq.size() > 0);
    chk("R11", "tx_valid", tx_valid, etv);
    if (etv) chk("R2", "tx_data", tx_data, txq[0]);
    chk("R11", "rx_ready", rx_ready, rxq.size() < capn());
    chk("R5", "tx_space_flag", tx_space_flag, e_txflag());
    chk("R5", "rx_data_flag", rx_data_flag, e_rxflag());
    chk("R9", "tx_frozen", tx_frozen, m_lock);
    reg_wr = s_wr; reg_rd = s_rd; reg_addr = s_addr; reg_word = s_word; reg_wdata = s_wd;
    tx_ready = s_txr; rx_valid = s_rxv; rx_data = s_rxd; xfer_error = s_err;
    #1;
    if (s_rd) chk(rd_tag, "reg_rdata", reg_rdata, exp_rdata());
    model_update();
    s_wr = 0; s_rd = 0; s_word = 0; s_err = 0;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic w);
    s_wr = 1; s_addr = a; s_wd = d; s_word = w;
    step();
  endtask

  task automatic rd(logic [7:0] a, logic w, string tag);
    s_rd = 1; s_addr = a; s_word = w; rd_tag = tag;
    step();
  endtask

  task automatic idle(int n);
    repeat (n) step();
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    rd(A_LEVEL, 0, "R1");
    rd(A_STAT, 0, "R1");
    rd(A_MODE, 0, "R1");

    // R6: queues off, single-slot behaviour
    wr(A_THR, 32'hA5, 0);
    wr(A_THR, 32'h5A, 0);               // dropped, overflow (R4)
    rd(A_STAT, 0, "R4");
    rd(A_LEVEL, 0, "R6");
    wr(A_MODE, 32'h22, 0);              // thresholds ignored while off
    s_rxv = 1; s_rxd = 8'h11; idle(1);
    s_rxd = 8'h12; idle(1);             // held off by rx_ready low
    s_rxv = 0;
    rd(A_STAT, 0, "R6");
    rd(A_RHR, 0, "R2");
    rd(A_RHR, 0, "R4");                 // underflow
    wr(A_THR, 32'h01020304, 1);         // word refused when off (R6)
    rd(A_LEVEL, 0, "R6");

    // R7: enable empties both queues
    wr(A_CTRL, 32'h1000_0000, 0);
    rd(A_STAT, 0, "R7");
    rd(A_LEVEL, 0, "R7");

    // R3: word writes fill to capacity
    wr(A_THR, 32'h44332211, 1);
    wr(A_THR, 32'h88776655, 1);
    wr(A_THR, 32'hCCBBAA99, 1);
    rd(A_STAT, 0, "R5");                // four free, four-slot threshold met
    wr(A_THR, 32'h00FFEEDD, 1);
    wr(A_THR, 32'h12345678, 1);         // full: dropped
    rd(A_LEVEL, 0, "R10");
    s_txr = 1; idle(5); s_txr = 0;
    wr(A_THR, 32'hDEADBEEF, 1);         // five free: accepted
    wr(A_THR, 32'hCAFEF00D, 1);         // one free: refused
    wr(A_THR, 32'h77, 0);
    rd(A_LEVEL, 0, "R10");

    // R8: flush both at once clears stickies
    wr(A_CTRL, 32'h0300_0000, 0);
    rd(A_STAT, 0, "R8");
    rd(A_LEVEL, 0, "R8");

    // R3/R5: receive with four-entry threshold
    s_rxv = 1;
    for (int i = 0; i < 6; i++) begin
      s_rxd = 8'h80 + 8'(i);
      step();
    end
    s_rxv = 0;
    rd(A_RHR, 1, "R3");
    rd(A_STAT, 0, "R5");
    rd(A_RHR, 1, "R4");                 // only two stored
    rd(A_RHR, 0, "R2");
    rd(A_LEVEL, 0, "R10");

    // R9: lock behaviour
    wr(A_THR, 32'h0000_5566, 0);
    wr(A_THR, 32'h0000_7788, 0);
    s_err = 1; step();
    s_txr = 1; idle(3);
    wr(A_THR, 32'h99, 0);               // still accepted while locked
    rd(A_STAT, 0, "R9");
    s_wr = 1; s_addr = A_CTRL; s_wd = 32'h0400_0000; s_err = 1; step();  // error wins
    rd(A_STAT, 0, "R9");
    wr(A_CTRL, 32'h0400_0000, 0);       // unlock only
    idle(4);
    wr(A_THR, 32'h11, 0);
    s_err = 1; step();
    wr(A_CTRL, 32'h0500_0000, 0);       // unlock and flush transmit
    rd(A_LEVEL, 0, "R8");
    s_txr = 0;

    // R8: flush racing a shifter transfer
    wr(A_THR, 32'h0A0B0C0D, 1);
    s_txr = 1; s_rxv = 1; s_rxd = 8'h3C;
    wr(A_CTRL, 32'h0300_0000, 0);
    s_txr = 0; s_rxv = 0;
    rd(A_LEVEL, 0, "R8");

    // R7: enable and disable together -> off
    wr(A_CTRL, 32'h3000_0000, 0);
    rd(A_STAT, 0, "R7");
    wr(A_CTRL, 32'h1000_0000, 0);

    // Mixed traffic
    for (int k = 0; k < 4000; k++) begin
      int r;
      r = $urandom_range(0, 29);
      s_txr = 1'($urandom_range(0, 1));
      s_rxv = 1'($urandom_range(0, 1));
      s_rxd = 8'($urandom);
      s_err = ($urandom_range(0, 199) == 0);
      if (r < 6)       wr(A_THR, $urandom, 0);
      else if (r < 10) wr(A_THR, $urandom, 1);
      else if (r < 14) rd(A_RHR, 0, "R2");
      else if (r < 17) rd(A_RHR, 1, "R3");
      else if (r == 17) wr(A_MODE, $urandom, 0);
      else if (r == 18) wr(A_CTRL, {5'b0, 1'b1, 1'($urandom_range(0, 1)), 25'b0}, 0);
      else if (r == 19) rd(A_LEVEL, 0, "R10");
      else if (r == 20) rd(A_STAT, 0, "R4");
      else if (r == 21 && $urandom_range(0, 9) == 0)
        wr(A_CTRL, ($urandom_range(0, 5) == 0) ? 32'h2000_0000 : 32'h1000_0000, 0);
      else if (r == 22) wr(A_CTRL, 32'h0500_0000, 0);
      else step();
    end
    s_txr = 0; s_rxv = 0;
    idle(2);
    finish_up();
  end
endmodule